// File: doc/BRIEF.md
# NAND Cache Read Pipeline Controller

This block sits on the host side of an 8-bit NAND bus and reads a batch of pages while keeping the array busy. The first page of a batch is loaded with an ordinary page read. Each later page is fetched into the device's data register by a cache read command. While that fetch runs, the previous page is streamed out of the cache register. When the batch ends, a closing cache command moves the last fetched page into the cache without starting another array access.

Requests arrive one at a time through a valid/ready handshake. Each request carries a page (row) address and a flag that marks the last request of the batch. For every request after the first, the controller compares the page with the one before it. A page that follows on directly gets the short sequential cache command. Any other page gets the random form with a full address. Read data leaves as a byte stream, and a flag marks the final byte of each page. A busy watchdog reports a device that holds its ready/busy line low for too long.

Top module: `nand_cache_rd_ctrl`

## Requirements
- R1: The first request of a batch issues command 00h, then five address bytes, then command 30h. The address bytes are column low = 0, column high = 0, then row bits 7:0, 15:8 and 23:16. Command bytes carry `nand_cle`=1 and address bytes carry `nand_ale`=1. Each byte is valid on `nand_dq_out` during the single cycle in which `nand_we_n` is low.
- R2: A later request whose page equals the previous page plus one issues the single command byte 31h.
- R3: A later request whose page is any other value issues 00h, five address bytes laid out as in R1, and then 31h.
- R4: After the last request of a batch with two or more pages, the controller issues the single command byte 3Fh. A batch of one page issues no 31h and no 3Fh.
- R5: After every 30h, 31h or 3Fh the controller waits for `nand_rb_n` to be high before it reads. `nand_re_n` never goes low while `nand_rb_n` is low. In a multi-page batch, page k is read out only after the confirm command for the next page (31h or 3Fh) has been issued.
- R6: Each page is read from column 0 for PAGE_BYTES bytes. Each byte is captured from `nand_dq_in` during a low pulse of `nand_re_n` and appears with a one-cycle `out_valid` pulse. Pages come out in request order. `out_page_end` is high with the last byte of a page only.
- R7: `req_ready` is high only while the controller is idle or waiting for the next request of a running batch. After a handshake, `req_ready` is low in the next cycle. Once a batch has finished, `req_ready` is high again.
- R8: `err_busy_timeout` is set if `nand_rb_n` stays low during one busy wait for more than `busy_limit` cycles. It rises only after a cycle in which `nand_rb_n` was low. It stays set until reset, and it is not set by busy periods shorter than the limit.
- R9: During and after reset, `req_ready`=1, `nand_we_n`=1, `nand_re_n`=1, `nand_cle`=0, `nand_ale`=0, `out_valid`=0 and `err_busy_timeout`=0.
- R10: `nand_cle` and `nand_ale` are never both high, and `nand_we_n` and `nand_re_n` are never both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A page request is offered |
| req_ready | output | 1 | The controller accepts a request this cycle |
| req_page | input | ROW_W | Row address of the requested page |
| req_last | input | 1 | The request closes the batch |
| busy_limit | input | WD_W | Longest allowed busy period, in cycles |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Command or address byte driven to the bus |
| nand_dq_oe | output | 1 | The controller drives the data bus |
| nand_dq_in | input | 8 | Data byte from the bus |
| nand_rb_n | input | 1 | Device ready (1) or busy (0) |
| out_valid | output | 1 | A read byte is valid |
| out_data | output | 8 | Read byte |
| out_page_end | output | 1 | Marks the last byte of a page |
| err_busy_timeout | output | 1 | Sticky busy watchdog error |

## Verification
Two things can coincide in one cycle: the host offering its next request and the controller still streaming the previous page out of the cache. The bench presents each request as soon as the previous one has been accepted and keeps `req_valid` high through the whole readout. Judgment works as follows. No byte may be lost or reordered in the data scoreboard. The command scoreboard must show the next 31h or random sequence only after the current wait has finished. A count of confirm commands taken at the first byte of each page must show that readout came after the next fetch had started.

// File: rtl/nand_crd_pkg.sv
package nand_crd_pkg;

    localparam int ROW_BITS = 24;

    localparam logic [7:0] OP_READ      = 8'h00;
    localparam logic [7:0] OP_LOAD      = 8'h30;
    localparam logic [7:0] OP_CACHE     = 8'h31;
    localparam logic [7:0] OP_CACHE_END = 8'h3F;

    typedef enum logic [1:0] {
        MODE_PAGE,
        MODE_SEQ,
        MODE_RAND,
        MODE_FINAL
    } crd_mode_e;

    typedef struct packed {
        logic       is_cmd;
        logic [7:0] val;
    } bus_item_t;

    function automatic logic [2:0] seq_len(crd_mode_e m);
        return (m == MODE_SEQ || m == MODE_FINAL) ? 3'd1 : 3'd7;
    endfunction

    function automatic bus_item_t seq_item(crd_mode_e m, logic [ROW_BITS-1:0] row,
                                           logic [2:0] idx);
        bus_item_t it;
        it = '{is_cmd: 1'b0, val: 8'h00};
        if (m == MODE_SEQ) begin
            it = '{is_cmd: 1'b1, val: OP_CACHE};
        end else if (m == MODE_FINAL) begin
            it = '{is_cmd: 1'b1, val: OP_CACHE_END};
        end else begin
            case (idx)
                3'd0:    it = '{is_cmd: 1'b1, val: OP_READ};
                3'd1:    it = '{is_cmd: 1'b0, val: 8'h00};
                3'd2:    it = '{is_cmd: 1'b0, val: 8'h00};
                3'd3:    it = '{is_cmd: 1'b0, val: row[7:0]};
                3'd4:    it = '{is_cmd: 1'b0, val: row[15:8]};
                3'd5:    it = '{is_cmd: 1'b0, val: row[23:16]};
                default: it = '{is_cmd: 1'b1, val: (m == MODE_PAGE) ? OP_LOAD : OP_CACHE};
            endcase
        end
        return it;
    endfunction

endpackage

// File: rtl/nand_crd_cmd_seq.sv
module nand_crd_cmd_seq
    import nand_crd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  crd_mode_e           mode,
    input  logic [ROW_BITS-1:0] row,
    output logic                cle,
    output logic                ale,
    output logic                we_n,
    output logic                dq_oe,
    output logic [7:0]          dq,
    output logic                done
);
    logic                active, ph;
    logic [2:0]          idx;
    crd_mode_e           mode_q;
    logic [ROW_BITS-1:0] row_q;
    bus_item_t           item;

    assign item  = seq_item(mode_q, row_q, idx);
    assign we_n  = !(active && !ph);
    assign cle   = active && item.is_cmd;
    assign ale   = active && !item.is_cmd;
    assign dq_oe = active;
    assign dq    = active ? item.val : 8'h00;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            ph     <= 1'b0;
            idx    <= '0;
            mode_q <= MODE_PAGE;
            row_q  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                active <= 1'b1;
                ph     <= 1'b0;
                idx    <= '0;
                mode_q <= mode;
                row_q  <= row;
            end else if (active) begin
                if (!ph) begin
                    ph <= 1'b1;
                end else begin
                    ph <= 1'b0;
                    if (idx == seq_len(mode_q) - 3'd1) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        idx <= idx + 3'd1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/nand_crd_busy_wait.sv
module nand_crd_busy_wait #(
    parameter int GUARD_CYC = 3,
    parameter int WD_W      = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  logic            rb_n,
    input  logic [WD_W-1:0] limit,
    output logic            done,
    output logic            err
);
    localparam int GW = $clog2(GUARD_CYC + 1);

    logic            active;
    logic [GW-1:0]   guard;
    logic [WD_W-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            guard   <= '0;
            low_cnt <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                active  <= 1'b1;
                guard   <= GW'(GUARD_CYC);
                low_cnt <= '0;
            end else if (active) begin
                if (!rb_n) begin
                    if (low_cnt == limit) err <= 1'b1;
                    if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
                end
                if (guard != '0) begin
                    guard <= guard - 1'b1;
                end else if (rb_n) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/nand_crd_page_reader.sv
module nand_crd_page_reader #(
    parameter int PAGE_BYTES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] dq_in,
    output logic       re_n,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       byte_last,
    output logic       done
);
    localparam int COL_W = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
    localparam logic [COL_W-1:0] COL_END = COL_W'(PAGE_BYTES - 1);

    logic             active, ph;
    logic [COL_W-1:0] col;

    assign re_n = !(active && !ph);

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            ph         <= 1'b0;
            col        <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            byte_last  <= 1'b0;
            done       <= 1'b0;
        end else begin
            done       <= 1'b0;
            byte_valid <= 1'b0;
            byte_last  <= 1'b0;
            if (go) begin
                active <= 1'b1;
                ph     <= 1'b0;
                col    <= '0;
            end else if (active) begin
                if (!ph) begin
                    byte_valid <= 1'b1;
                    byte_data  <= dq_in;
                    byte_last  <= (col == COL_END);
                    ph         <= 1'b1;
                end else begin
                    ph <= 1'b0;
                    if (col == COL_END) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        col <= col + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/nand_cache_rd_ctrl.sv
module nand_cache_rd_ctrl
    import nand_crd_pkg::*;
#(
    parameter int ROW_W      = 24,
    parameter int PAGE_BYTES = 16,
    parameter int WD_W       = 16,
    parameter int GUARD_CYC  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] req_page,
    input  logic             req_last,
    input  logic [WD_W-1:0]  busy_limit,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_dq_out,
    output logic             nand_dq_oe,
    input  logic [7:0]       nand_dq_in,
    input  logic             nand_rb_n,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_page_end,
    output logic             err_busy_timeout
);
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WAIT,
        ST_NEXT,
        ST_READ
    } ctl_state_e;

    ctl_state_e          state;
    logic [ROW_W-1:0]    prev_page;
    logic                last_seen, finishing, first_load;
    logic                seq_go, busy_go, rd_go;
    crd_mode_e           seq_mode;
    logic [ROW_BITS-1:0] seq_row;
    logic                seq_done, busy_done, rd_done;
    logic                accept;

    assign req_ready = (state == ST_IDLE) || (state == ST_NEXT);
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            prev_page  <= '0;
            last_seen  <= 1'b0;
            finishing  <= 1'b0;
            first_load <= 1'b0;
            seq_go     <= 1'b0;
            busy_go    <= 1'b0;
            rd_go      <= 1'b0;
            seq_mode   <= MODE_PAGE;
            seq_row    <= '0;
        end else begin
            seq_go  <= 1'b0;
            busy_go <= 1'b0;
            rd_go   <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    prev_page  <= req_page;
                    seq_row    <= ROW_BITS'(req_page);
                    seq_mode   <= MODE_PAGE;
                    seq_go     <= 1'b1;
                    last_seen  <= req_last;
                    finishing  <= 1'b0;
                    first_load <= 1'b1;
                    state      <= ST_CMD;
                end
                ST_CMD: if (seq_done) begin
                    busy_go <= 1'b1;
                    state   <= ST_WAIT;
                end
                ST_WAIT: if (busy_done) begin
                    if (first_load && !last_seen) begin
                        first_load <= 1'b0;
                        state      <= ST_NEXT;
                    end else begin
                        if (first_load) finishing <= 1'b1;
                        first_load <= 1'b0;
                        rd_go      <= 1'b1;
                        state      <= ST_READ;
                    end
                end
                ST_NEXT: if (accept) begin
                    prev_page <= req_page;
                    seq_row   <= ROW_BITS'(req_page);
                    seq_mode  <= (req_page == prev_page + ROW_W'(1)) ? MODE_SEQ : MODE_RAND;
                    seq_go    <= 1'b1;
                    last_seen <= req_last;
                    state     <= ST_CMD;
                end
                ST_READ: if (rd_done) begin
                    if (finishing) begin
                        state <= ST_IDLE;
                    end else if (last_seen) begin
                        finishing <= 1'b1;
                        seq_mode  <= MODE_FINAL;
                        seq_go    <= 1'b1;
                        state     <= ST_CMD;
                    end else begin
                        state <= ST_NEXT;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    nand_crd_cmd_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .go    (seq_go),
        .mode  (seq_mode),
        .row   (seq_row),
        .cle   (nand_cle),
        .ale   (nand_ale),
        .we_n  (nand_we_n),
        .dq_oe (nand_dq_oe),
        .dq    (nand_dq_out),
        .done  (seq_done)
    );

    nand_crd_busy_wait #(.GUARD_CYC(GUARD_CYC), .WD_W(WD_W)) u_busy (
        .clk   (clk),
        .rst   (rst),
        .go    (busy_go),
        .rb_n  (nand_rb_n),
        .limit (busy_limit),
        .done  (busy_done),
        .err   (err_busy_timeout)
    );

    nand_crd_page_reader #(.PAGE_BYTES(PAGE_BYTES)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .go         (rd_go),
        .dq_in      (nand_dq_in),
        .re_n       (nand_re_n),
        .byte_valid (out_valid),
        .byte_data  (out_data),
        .byte_last  (out_page_end),
        .done       (rd_done)
    );
endmodule

// File: rtl/nand_crd_chk.sv
module nand_crd_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic nand_cle,
    input logic nand_ale,
    input logic nand_we_n,
    input logic nand_re_n,
    input logic nand_rb_n,
    input logic out_valid,
    input logic out_page_end,
    input logic err_busy_timeout
);
    a_r10_cle_ale_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));
    a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n));
    a_r5_read_only_when_ready: assert property (@(posedge clk) disable iff (rst)
        !nand_re_n |-> nand_rb_n);
    a_r6_end_with_byte: assert property (@(posedge clk) disable iff (rst)
        out_page_end |-> out_valid);
    a_r6_single_cycle_byte: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    a_r7_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_busy_timeout |=> err_busy_timeout);
    a_r8_err_after_low: assert property (@(posedge clk) disable iff (rst)
        $rose(err_busy_timeout) |-> !$past(nand_rb_n));
endmodule

bind nand_cache_rd_ctrl nand_crd_chk chk_i (
    .clk              (clk),
    .rst              (rst),
    .req_valid        (req_valid),
    .req_ready        (req_ready),
    .nand_cle         (nand_cle),
    .nand_ale         (nand_ale),
    .nand_we_n        (nand_we_n),
    .nand_re_n        (nand_re_n),
    .nand_rb_n        (nand_rb_n),
    .out_valid        (out_valid),
    .out_page_end     (out_page_end),
    .err_busy_timeout (err_busy_timeout)
);

// File: tb/nand_cache_rd_ctrl_tb_top.sv
module nand_cache_rd_ctrl_tb_top;
    localparam int PB = 16;
    localparam int RW = 24;
    localparam int WW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [RW-1:0] req_page = '0;
    logic          req_last = 1'b0;
    logic [WW-1:0] busy_limit = 16'd20;
    logic          nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]    nand_dq_out, nand_dq_in;
    logic          nand_rb_n;
    logic          out_valid, out_page_end, err_busy_timeout;
    logic [7:0]    out_data;

    always #10 clk = ~clk;

    nand_cache_rd_ctrl #(.ROW_W(RW), .PAGE_BYTES(PB), .WD_W(WW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_page(req_page), .req_last(req_last), .busy_limit(busy_limit),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb_n(nand_rb_n), .out_valid(out_valid),
        .out_data(out_data), .out_page_end(out_page_end),
        .err_busy_timeout(err_busy_timeout)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit [8:0] exp_cmd[$];
    bit [8:0] exp_dat[$];
    int       exp_conf[$];
    int       pq[$];
    int       conf_base = 0;
    int       conf_seen = 0;
    int       byte_idx = 0;
    int       re_viol = 0;

    // device model
    int         busy_len = 6;
    int         dcache = 0, ddreg = 0, dcol = 0, bcnt = 0, acnt = 0;
    bit         rnd = 1'b0;
    logic [7:0] abuf[5];

    function automatic logic [7:0] pat(int p, int c);
        return 8'(p * 13 + c * 7 + 1);
    endfunction

    assign nand_rb_n  = (bcnt == 0);
    assign nand_dq_in = pat(dcache, dcol);

    always @(posedge clk) begin
        if (rst) begin
            bcnt <= 0; dcol <= 0; dcache <= 0; ddreg <= 0; acnt <= 0; rnd <= 1'b0;
        end else begin
            if (bcnt != 0) bcnt <= bcnt - 1;
            if (!nand_we_n && nand_cle) begin
                case (nand_dq_out)
                    8'h00: begin acnt <= 0; rnd <= 1'b1; end
                    8'h30: begin
                        ddreg  <= {8'h0, abuf[4], abuf[3], abuf[2]};
                        dcache <= {8'h0, abuf[4], abuf[3], abuf[2]};
                        dcol <= 0; bcnt <= busy_len; rnd <= 1'b0;
                    end
                    8'h31: begin
                        dcache <= ddreg;
                        ddreg  <= rnd ? {8'h0, abuf[4], abuf[3], abuf[2]} : ((ddreg + 1) & 32'hFFFFFF);
                        dcol <= 0; bcnt <= busy_len; rnd <= 1'b0;
                    end
                    8'h3F: begin dcache <= ddreg; dcol <= 0; bcnt <= busy_len; end
                    default: ;
                endcase
            end else if (!nand_we_n && nand_ale) begin
                if (acnt < 5) abuf[acnt] <= nand_dq_out;
                acnt <= acnt + 1;
            end else if (!nand_re_n) begin
                dcol <= dcol + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // command scoreboard monitor (R1 R2 R3 R4)
    always @(negedge clk) begin
        if (!rst && !nand_we_n) begin
            if (exp_cmd.size() == 0) begin
                chk("R1/R2/R3/R4 unexpected bus byte", {23'h0, nand_cle, nand_dq_out}, 32'h1FF);
            end else begin
                automatic bit [8:0] e = exp_cmd.pop_front();
                chk("R1/R2/R3/R4 bus byte", {22'h0, nand_ale, nand_cle, nand_dq_out},
                    {22'h0, !e[8], e[8], e[7:0]});
            end
            if (nand_cle && (nand_dq_out == 8'h30 || nand_dq_out == 8'h31 || nand_dq_out == 8'h3F))
                conf_seen++;
        end
        if (!rst && !nand_re_n && !nand_rb_n) re_viol++;
    end

    // data scoreboard monitor (R5 R6)
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_dat.size() == 0) begin
                chk("R6 unexpected byte", {23'h0, out_page_end, out_data}, 32'h1FF);
            end else begin
                automatic bit [8:0] e = exp_dat.pop_front();
                if (byte_idx == 0 && exp_conf.size() != 0)
                    chk("R5 readout after next fetch", conf_seen, exp_conf.pop_front());
                chk("R6 read byte", {23'h0, out_page_end, out_data}, {23'h0, e});
            end
            byte_idx = (byte_idx == PB - 1) ? 0 : byte_idx + 1;
        end
    end

    task automatic push_full(input bit [7:0] conf, input int p);
        exp_cmd.push_back({1'b1, 8'h00});
        exp_cmd.push_back({1'b0, 8'h00});
        exp_cmd.push_back({1'b0, 8'h00});
        exp_cmd.push_back({1'b0, 8'(p)});
        exp_cmd.push_back({1'b0, 8'(p >> 8)});
        exp_cmd.push_back({1'b0, 8'(p >> 16)});
        exp_cmd.push_back({1'b1, conf});
    endtask

    // driver: pushes expectations for the batch in pq, then hands requests over
    task automatic run_batch();
        automatic int n = pq.size();
        for (int i = 0; i < n; i++) begin
            if (i == 0) push_full(8'h30, pq[0]);
            else if (pq[i] == ((pq[i-1] + 1) & 32'hFFFFFF)) exp_cmd.push_back({1'b1, 8'h31});
            else push_full(8'h31, pq[i]);
            exp_conf.push_back(conf_base + ((n > 1) ? i + 2 : 1));
            for (int c = 0; c < PB; c++)
                exp_dat.push_back({(c == PB - 1), pat(pq[i], c)});
        end
        if (n > 1) exp_cmd.push_back({1'b1, 8'h3F});
        conf_base += (n > 1) ? n + 1 : 1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_page  = RW'(pq[i]);
            req_last  = (i == n - 1);
            do @(posedge clk); while (!req_ready);
        end
        @(negedge clk);
        req_valid = 1'b0;
        req_last  = 1'b0;
        while (exp_dat.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
        chk("R7 ready after batch", req_ready, 1);
        chk("R4 no extra commands pending", exp_cmd.size(), 0);
        pq.delete();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run hung, actual running expected done");
        finish_run();
    end

    task automatic check_reset_state();
        chk("R9 ready", req_ready, 1);
        chk("R9 we_n", nand_we_n, 1);
        chk("R9 re_n", nand_re_n, 1);
        chk("R9 cle/ale", {nand_cle, nand_ale}, 0);
        chk("R9 out_valid", out_valid, 0);
        chk("R9 err", err_busy_timeout, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 single-page batch, R4 no cache commands
        pq.push_back(5); run_batch();
        // R2 sequential run
        pq.push_back(10); pq.push_back(11); pq.push_back(12); pq.push_back(13); run_batch();
        // R3 mixed, wide row address bytes
        pq.push_back(24'h123456); pq.push_back(24'h123457); pq.push_back(40); pq.push_back(7);
        run_batch();
        // R3 descending pages, two-page batch
        pq.push_back(100); pq.push_back(99); run_batch();
        // R2 row carry across a byte
        pq.push_back(24'h0000FF); pq.push_back(24'h000100); run_batch();
        chk("R8 no error on short busy", err_busy_timeout, 0);

        // R8 busy longer than the limit
        busy_len = 40;
        pq.push_back(77); run_batch();
        chk("R8 error on long busy", err_busy_timeout, 1);
        busy_len = 6;
        pq.push_back(200); pq.push_back(300); run_batch();
        chk("R8 error sticky", err_busy_timeout, 1);
        chk("R5 no read strobe while busy", re_viol, 0);

        // R9 reset clears state
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        repeat (2) @(negedge clk);
        pq.push_back(9); pq.push_back(10); run_batch();
        chk("R8 clear after reset", err_busy_timeout, 0);
        finish_run();
    end
endmodule